// File: doc/BRIEF.md
# Floating-Point Mantissa Quantizer

This block lowers the precision of a single-precision-format value by rounding its mantissa to a chosen number of fraction bits. The sign and exponent are kept, so the step between neighbouring output levels scales with the magnitude of the value. The relative error is therefore bounded by 2^-b, where b is the number of retained bits. A fixed absolute step would not behave this way. The retained bit count is picked per sample at run time. An enable input lets a sample pass through untouched.

Each accepted sample produces two results one clock later: the quantized value, and the signed error x − Q(x). The error is given in units of the input's least-significant fraction bit, at the input's exponent. Zero, subnormal, infinite and NaN inputs are passed through as they are, with zero error.

Top module: `fq_quantizer`

## Requirements
- R1: While reset is low at a clock edge, out_valid, out_value and out_err all become zero.
- R2: out_valid equals in_valid from the previous cycle. out_value and out_err update only in cycles where in_valid is high, and otherwise hold their values.
- R3: For an enabled normal input (exponent field 1..254), bit 31 is the sign, bits 30:23 the biased exponent and bits 22:0 the fraction. The mantissa 1.frac is rounded to nearest at b fraction bits. The fraction bits below the top b are zero in the result. The sign is unchanged, and the exponent is unchanged unless R5 applies.
- R4: When the discarded bits equal exactly half a step, rounding goes to the level whose lowest retained bit is 0.
- R5: When rounding up carries out of the mantissa, the fraction becomes zero and the exponent rises by one.
- R6: When that carry would make the exponent 255, the result is infinity (exponent 255, fraction 0) carrying the input sign.
- R7: out_err is a 25-bit two's-complement count of input fraction LSBs equal to x − Q(x) at the input exponent. It is positive when rounding down and negative when rounding up.
- R8: With in_enable low, out_value equals the input and out_err is zero.
- R9: Inputs with exponent field 0 (zero or subnormal) or 255 (infinity or NaN) pass through unchanged, with out_err zero.
- R10: in_bits is an unsigned 4-bit count. A value of 0 is treated as 1, and values above 10 are treated as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_value | input | 32 | Input value: sign, biased exponent, fraction |
| in_bits | input | 4 | Number of retained fraction bits |
| in_enable | input | 1 | High to quantize, low to bypass |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_value | output | 32 | Quantized value |
| out_err | output | 25 | Signed error x − Q(x), in input fraction LSBs |

## Verification
Random normal values across all bit counts from 0 to 15 check round-to-nearest and the error sign against a reference model based on integer division. Directed values at exactly half a step, with the lowest retained bit first even and then odd, separate a tie-to-even rounder from a round-half-up rounder. An all-ones fraction at exponents 127 and 254 separates a correct carry into the exponent from an overflow to infinity. Zero, subnormal, infinity, NaN and disabled samples show that pass-through is exact. An idle cycle shows that the outputs hold.

// File: rtl/fq_pkg.sv
// Package fq_pkg
// Shared defaults and the operand class type for the mantissa quantizer.
package fq_pkg;
    localparam int FQ_EXP_W    = 8;
    localparam int FQ_FRAC_W   = 23;
    localparam int FQ_MAX_BITS = 10;
    localparam int FQ_BITS_W   = 4;

    typedef enum logic [1:0] {
        CLS_NORMAL  = 2'd0,
        CLS_ZERO    = 2'd1,
        CLS_TINY    = 2'd2,
        CLS_SPECIAL = 2'd3
    } fq_class_e;
endpackage

// File: rtl/fq_classify.sv
// Module fq_classify
// Sorts an operand into normal, zero, subnormal or inf/NaN classes.
// Assumes a biased exponent in which all ones marks inf/NaN.
module fq_classify
    import fq_pkg::*;
#(
    parameter int EXP_W  = FQ_EXP_W,
    parameter int FRAC_W = FQ_FRAC_W
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output fq_class_e         cls_o
);
    // Decode the class from the exponent and the fraction.
    always_comb begin
        if (&exp_i)               cls_o = CLS_SPECIAL;
        else if (exp_i != '0)     cls_o = CLS_NORMAL;
        else if (frac_i == '0)    cls_o = CLS_ZERO;
        else                      cls_o = CLS_TINY;
    end
endmodule

// File: rtl/fq_round.sv
// Module fq_round
// Rounds a normal operand's mantissa to nearest (ties to even) at a clamped
// bit count. Handles carry into the exponent and overflow to infinity, and
// reports x - Q(x) in input fraction LSBs.
// Assumes the operand is normal; the caller muxes other classes.
module fq_round
    import fq_pkg::*;
#(
    parameter int EXP_W    = FQ_EXP_W,
    parameter int FRAC_W   = FQ_FRAC_W,
    parameter int MAX_BITS = FQ_MAX_BITS,
    parameter int BITS_W   = FQ_BITS_W
) (
    input  logic [EXP_W-1:0]        exp_i,
    input  logic [FRAC_W-1:0]       frac_i,
    input  logic [BITS_W-1:0]       bits_i,
    output logic [EXP_W-1:0]        exp_o,
    output logic [FRAC_W-1:0]       frac_o,
    output logic signed [FRAC_W+1:0] err_o
);
    localparam int MW   = FRAC_W + 1;
    localparam int SH_W = $clog2(FRAC_W + 1);

    logic [BITS_W-1:0] b_eff;
    logic [SH_W-1:0]   drop;
    logic [MW-1:0]     mant, step, low, half, trunc;
    logic              keep_lsb, round_up;
    logic [MW:0]       sum;
    logic [EXP_W-1:0]  exp_inc;

    // Clamp the requested bit count into 1..MAX_BITS.
    always_comb begin
        if (bits_i == '0)                          b_eff = BITS_W'(1);
        else if (bits_i > BITS_W'(MAX_BITS))       b_eff = BITS_W'(MAX_BITS);
        else                                       b_eff = bits_i;
    end

    // Split the mantissa into kept and discarded parts and decide the rounding.
    always_comb begin
        drop     = SH_W'(FRAC_W) - SH_W'(b_eff);
        mant     = {1'b1, frac_i};
        step     = MW'(1) << drop;
        low      = mant & (step - MW'(1));
        half     = step >> 1;
        trunc    = mant & ~(step - MW'(1));
        keep_lsb = |(mant & step);
        round_up = (low > half) || ((low == half) && keep_lsb);
    end

    // Apply the increment, and move any carry into the exponent or to infinity.
    always_comb begin
        sum     = {1'b0, trunc} + (round_up ? {1'b0, step} : '0);
        exp_inc = exp_i + EXP_W'(1);
        err_o   = $signed({2'b00, low}) - (round_up ? $signed({2'b00, step}) : '0);
        if (sum[MW]) begin
            exp_o  = exp_inc;
            frac_o = '0;
        end else begin
            exp_o  = exp_i;
            frac_o = sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fq_quantizer.sv
// Module fq_quantizer
// Top of the mantissa quantizer. Classifies the operand, rounds normal
// enabled operands, and registers the value and error with one cycle of
// latency. Assumes a synchronous active-low reset.
module fq_quantizer
    import fq_pkg::*;
#(
    parameter int EXP_W    = FQ_EXP_W,
    parameter int FRAC_W   = FQ_FRAC_W,
    parameter int MAX_BITS = FQ_MAX_BITS,
    parameter int BITS_W   = FQ_BITS_W,
    localparam int W       = 1 + EXP_W + FRAC_W,
    localparam int ERR_W   = FRAC_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [W-1:0]            in_value,
    input  logic [BITS_W-1:0]       in_bits,
    input  logic                    in_enable,
    output logic                    out_valid,
    output logic [W-1:0]            out_value,
    output logic signed [ERR_W-1:0] out_err
);
    logic              sgn;
    logic [EXP_W-1:0]  exp_in, exp_r;
    logic [FRAC_W-1:0] frac_in, frac_r;
    logic signed [ERR_W-1:0] err_r;
    fq_class_e         cls;
    logic [W-1:0]      nxt_value;
    logic signed [ERR_W-1:0] nxt_err;

    assign sgn     = in_value[W-1];
    assign exp_in  = in_value[W-2:FRAC_W];
    assign frac_in = in_value[FRAC_W-1:0];

    fq_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .exp_i(exp_in), .frac_i(frac_in), .cls_o(cls)
    );

    fq_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .MAX_BITS(MAX_BITS), .BITS_W(BITS_W)) u_rnd (
        .exp_i(exp_in), .frac_i(frac_in), .bits_i(in_bits),
        .exp_o(exp_r), .frac_o(frac_r), .err_o(err_r)
    );

    // Choose between pass-through and the rounded result.
    always_comb begin
        if (!in_enable || cls != CLS_NORMAL) begin
            nxt_value = in_value;
            nxt_err   = '0;
        end else if (&exp_r) begin
            nxt_value = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            nxt_err   = err_r;
        end else begin
            nxt_value = {sgn, exp_r, frac_r};
            nxt_err   = err_r;
        end
    end

    // Output register: clear on reset, capture on a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_value <= '0;
            out_err   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_value <= nxt_value;
                out_err   <= nxt_err;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R3
    sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_value[W-1] == $past(in_value[W-1]));

    // R5
    exp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_value[W-2:FRAC_W] == $past(in_value[W-2:FRAC_W])) ||
                     (out_value[W-2:FRAC_W] == $past(in_value[W-2:FRAC_W]) + EXP_W'(1)));

    // R8
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_enable) |=> (out_value == $past(in_value)) && (out_err == '0));

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_err == '0) == (out_value == $past(in_value)));
endmodule

// File: tb/fq_quantizer_bench.sv
module fq_quantizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_value = '0;
    logic [3:0]  in_bits = '0;
    logic        in_enable = 1'b0;
    logic        out_valid;
    logic [31:0] out_value;
    logic signed [24:0] out_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fq_quantizer u_fq_quantizer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .in_bits(in_bits), .in_enable(in_enable), .out_valid(out_valid),
        .out_value(out_value), .out_err(out_err)
    );

    // Reference model built from integer division on the full mantissa.
    function automatic void model(input logic [31:0] x, input logic [3:0] bits_in,
                                  input logic en, output logic [31:0] q, output int err);
        int b, e;
        longint m, stp, t, r;
        b = (bits_in == 0) ? 1 : ((bits_in > 10) ? 10 : int'(bits_in));
        e = int'(x[30:23]);
        if (!en || e == 0 || e == 255) begin
            q = x; err = 0;
        end else begin
            m   = longint'({1'b1, x[22:0]});
            stp = longint'(1) << (23 - b);
            t   = (m / stp) * stp;
            r   = m - t;
            if (2 * r > stp || (2 * r == stp && ((t / stp) % 2) == 1)) t = t + stp;
            err = int'(m - t);
            if (t == (longint'(1) << 24)) begin
                e = e + 1; t = longint'(1) << 23;
            end
            if (e == 255) q = {x[31], 8'hff, 23'd0};
            else          q = {x[31], e[7:0], t[22:0]};
        end
    endfunction

    task automatic check(input string req, input logic [31:0] av, input logic [31:0] ev,
                         input int ae, input int ee);
        total++;
        if (av !== ev || ae != ee) begin
            bad++;
            $display("FAIL %s value=%h err=%0d expected value=%h err=%0d", req, av, ae, ev, ee);
        end
    endtask

    // Drive one sample at a falling edge, then check it one cycle later.
    task automatic run(input string req, input logic [31:0] x, input logic [3:0] b, input logic en);
        logic [31:0] q;
        int e;
        model(x, b, en, q, e);
        @(negedge clk);
        in_valid = 1'b1; in_value = x; in_bits = b; in_enable = en;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, out_value, q, int'(out_err), e);
        check("R2", {31'd0, out_valid}, 32'd1, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog value=0 err=0 expected value=done err=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", out_value, 32'd0, int'(out_err), 0);
        check("R1", {31'd0, out_valid}, 32'd0, 0, 0);
        rst_n = 1'b1;

        // R3 exact value, no change
        run("R3", 32'h3f80_0000, 4'd1, 1'b1);
        // R3 round down at b=10
        run("R3", 32'h4049_0fdb, 4'd10, 1'b1);
        // R4 tie, even lsb kept: drop 22, half 2^21
        run("R4", 32'h3f20_0000, 4'd1, 1'b1);
        // R4 tie, odd lsb rounds up and carries (R5)
        run("R4", 32'h3f60_0000, 4'd1, 1'b1);
        // R5 carry into exponent
        run("R5", 32'h3fff_ffff, 4'd5, 1'b1);
        // R6 overflow to infinity, both signs
        run("R6", 32'h7f7f_ffff, 4'd10, 1'b1);
        run("R6", 32'hff7f_ffff, 4'd3, 1'b1);
        // R7 negative error on round up
        run("R7", 32'hc0a3_ffff, 4'd8, 1'b1);
        // R8 bypass
        run("R8", 32'h4049_0fdb, 4'd1, 1'b0);
        // R9 zero, negative zero, subnormal, infinity, NaN
        run("R9", 32'h0000_0000, 4'd2, 1'b1);
        run("R9", 32'h8000_0000, 4'd2, 1'b1);
        run("R9", 32'h0012_3457, 4'd2, 1'b1);
        run("R9", 32'h7f80_0000, 4'd2, 1'b1);
        run("R9", 32'h7fc1_2345, 4'd2, 1'b1);
        // R10 clamp of the bit count
        run("R10", 32'h3fb3_3333, 4'd0, 1'b1);
        run("R10", 32'h3fb3_3333, 4'd15, 1'b1);

        // R2 hold while idle
        held = out_value;
        @(negedge clk);
        in_value = 32'h1234_5678;
        @(negedge clk);
        check("R2", out_value, held, 0, 0);
        check("R2", {31'd0, out_valid}, 32'd0, 0, 0);

        // R3 and R7 under random normal values
        for (int i = 0; i < 400; i++) begin
            logic [31:0] x;
            x = $urandom();
            if (x[30:23] == 8'd0 || x[30:23] == 8'hff) x[30:23] = 8'd100;
            run("R3", x, 4'($urandom_range(0, 15)), ($urandom_range(0, 7) != 0));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule